// File: doc/BRIEF.md
# Descriptor Ring DMA Channel

One channel of a descriptor-driven DMA engine. Software places 32-byte descriptors in memory, each holding a command word, a byte count, a source address and attribute word, a destination address and attribute word, a status slot and a pointer to the next descriptor. It then loads the pointer register, sets the enable bit and rings the doorbell. The channel reads the descriptor. It moves the data in read-then-write beats over a single-outstanding request/acknowledge memory port. On completion it writes back the descriptor, optionally raises its interrupt, and follows the chain to the next descriptor.

A descriptor whose valid bit is clear belongs to software. The channel parks on it and does nothing until the doorbell is written again. Clearing the enable bit stops the channel cleanly: the beat in flight finishes, the halt flag rises, and the byte-count register tells software how much of the current descriptor was left.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset the enable bit (CFG 0x00 bit 0) is 0, the halt flag (STAT 0x14 bit 0) is 1, irq is 0 and no memory request is made.
- R2: A fetch reads the word at pointer+0x00 (cmd0) first. If cmd0 bit 0 (valid) is 0, the channel makes no further access and parks. Otherwise it reads, in this order, offsets 0x04 (count), 0x08 (source address), 0x0C (source attributes), 0x10 (destination address), 0x14 (destination attributes) and 0x1C (next pointer).
- R3: Any write to the doorbell register (0x08) sets doorbell-pending (STAT bit 1). When the channel is idle with enable set and a doorbell pending, it re-fetches the descriptor at the pointer register (0x04). With enable clear, a doorbell only sets the pending bit.
- R4: cmd0[3:2] selects the source width and cmd0[5:4] the destination width (0 byte, 1 halfword, 2 or 3 word). Every beat moves the narrower of the two widths: a read, then a write of the same data, with mem_size carrying the width code. A count of N bytes takes ceil(N / beat bytes) beats.
- R5: Attribute bits [1:0] set the address mode of each side: 0 increments by the beat size, 1 keeps the address fixed, 2 or 3 is a burst window. In a burst window the byte offset wraps modulo units times the beat bytes, where bits [3:2] select 1, 2, 4 or 8 units.
- R6: After the last beat the channel writes count|0x8000_0000 to pointer+0x18, then writes cmd0 with bit 0 cleared to pointer+0x00. It then loads the next pointer into the pointer register and, if enabled, fetches from it at once.
- R7: A descriptor with count 0 makes no data beats and still performs the write-back of R6 and the interrupt of R8.
- R8: When cmd0 bit 1 is set, completing the descriptor sets irq and IRQ (0x0C) bit 0. Any write to 0x0C clears them. With cmd0 bit 1 clear, irq stays 0.
- R9: Once enable is cleared, the channel finishes the beat in flight and then stops. It makes no request, STAT bit 0 reads 1, and BCNT (0x10) holds the bytes still to move in the current descriptor.
- R10: STAT bit 2 is 1 while a valid descriptor is loaded and not yet written back. Writing 1 to STAT bit 1 clears doorbell-pending, and writing 1 to STAT bit 2 clears current-valid.
- R11: A memory request holds its address, direction, size and data unchanged until the cycle in which mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (8) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Channel interrupt |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | 32 | Byte address |
| mem_size | output | 2 | Access width code (0 byte, 1 half, 2 word) |
| mem_wdata | output | 32 | Write data, low lanes |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The reference model expands every descriptor into its expected sequence of bus transactions and compares each acknowledged access against it. A chain of word-wide, zero-count and invalid descriptors separates auto-advance, the zero-count shortcut and parking. A byte source feeding a word destination, and a word source feeding a halfword destination, check that the narrower width wins in both directions. The static and burst-window modes are told apart from increment by the repeated or wrapping addresses they produce. A disable in the middle of a long transfer, followed by a resume, checks the halt handshake, the remaining count, and the fact that a resumed descriptor restarts from its full count.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;
  localparam int DW         = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  // descriptor word slots (order is decoded by the fetch sequencer)
  localparam int IDX_C0   = 0;
  localparam int IDX_C1   = 1;
  localparam int IDX_S0   = 2;
  localparam int IDX_S1   = 3;
  localparam int IDX_D0   = 4;
  localparam int IDX_D1   = 5;
  localparam int IDX_STAT = 6;
  localparam int IDX_NEXT = 7;

  // register offsets
  localparam int OFF_CFG   = 'h00;
  localparam int OFF_DPTR  = 'h04;
  localparam int OFF_DBELL = 'h08;
  localparam int OFF_IRQ   = 'h0C;
  localparam int OFF_BCNT  = 'h10;
  localparam int OFF_STAT  = 'h14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RD, ST_WR, ST_WB_STAT, ST_WB_CMD
  } eng_st_e;

  // narrower of the two access widths; code 3 behaves as word
  function automatic logic [1:0] beat_code(input logic [1:0] sw, input logic [1:0] dw);
    logic [1:0] a, b;
    a = (sw == 2'd3) ? 2'd2 : sw;
    b = (dw == 2'd3) ? 2'd2 : dw;
    return (a < b) ? a : b;
  endfunction

  function automatic logic [DW-1:0] beat_bytes(input logic [1:0] wc);
    return DW'(1) << wc;
  endfunction

  // address of one side for a given byte offset into the descriptor
  function automatic logic [DW-1:0] side_addr(input logic [DW-1:0] base, input logic [3:0] attr,
                                              input logic [DW-1:0] off, input logic [1:0] wc);
    logic [2:0]    sh;
    logic [DW-1:0] win;
    sh  = {1'b0, attr[3:2]} + {1'b0, wc};
    win = DW'(1) << sh;
    case (attr[1:0])
      2'd0:    return base + off;
      2'd1:    return base;
      default: return base + (off & (win - DW'(1)));
    endcase
  endfunction
endpackage

// File: rtl/desc_dma_regs.sv
module desc_dma_regs
  import desc_dma_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              en,
  output logic              dbell_pend,
  output logic [DW-1:0]     dptr,
  output logic              irq,
  input  logic              fetch_go,
  input  logic              dptr_wr,
  input  logic [DW-1:0]     dptr_nxt,
  input  logic              irq_set,
  input  logic              cv_set,
  input  logic              cv_clr,
  input  logic              idle,
  input  logic [DW-1:0]     bcnt
);
  logic en_q, pend_q, irq_q, cv_q;
  logic [DW-1:0] dptr_q;

  wire wr_cfg   = reg_we && (reg_addr == REG_AW'(OFF_CFG));
  wire wr_dptr  = reg_we && (reg_addr == REG_AW'(OFF_DPTR));
  wire wr_dbell = reg_we && (reg_addr == REG_AW'(OFF_DBELL));
  wire wr_irq   = reg_we && (reg_addr == REG_AW'(OFF_IRQ));
  wire wr_stat  = reg_we && (reg_addr == REG_AW'(OFF_STAT));
  wire halt     = idle && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
      cv_q   <= 1'b0;
      dptr_q <= '0;
    end else begin
      if (wr_cfg) en_q <= reg_wdata[0];
      if (dptr_wr)      dptr_q <= dptr_nxt;
      else if (wr_dptr) dptr_q <= reg_wdata;
      pend_q <= wr_dbell | (pend_q & ~fetch_go & ~(wr_stat & reg_wdata[1]));
      cv_q   <= cv_set | (cv_q & ~cv_clr & ~(wr_stat & reg_wdata[2]));
      irq_q  <= irq_set | (irq_q & ~wr_irq);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_AW'(OFF_CFG):  reg_rdata[0] = en_q;
      REG_AW'(OFF_DPTR): reg_rdata = dptr_q;
      REG_AW'(OFF_IRQ):  reg_rdata[0] = irq_q;
      REG_AW'(OFF_BCNT): reg_rdata = bcnt;
      REG_AW'(OFF_STAT): reg_rdata[2:0] = {cv_q, pend_q, halt};
      default:           reg_rdata = '0;
    endcase
  end

  assign en         = en_q;
  assign dbell_pend = pend_q;
  assign dptr       = dptr_q;
  assign irq        = irq_q;

  // R8: the interrupt only rises after a completion that asked for it
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(irq_set));
  // R9: a halted channel stays halted until software writes a register
  p_halt_stays_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reg_we) |=> halt);
endmodule

// File: rtl/desc_dma_engine.sv
module desc_dma_engine
  import desc_dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dbell_pend,
  input  logic [DW-1:0] dptr,
  output logic          fetch_go,
  output logic          dptr_wr,
  output logic [DW-1:0] dptr_nxt,
  output logic          irq_set,
  output logic          cv_set,
  output logic          cv_clr,
  output logic          idle,
  output logic [DW-1:0] bcnt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [DW-1:0] mem_addr,
  output logic [1:0]    mem_size,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_ack,
  input  logic [DW-1:0] mem_rdata
);
  eng_st_e          st;
  logic [IDX_W-1:0] fidx;
  logic [DW-1:0]    c0, c1, s0, d0, nx, buf_q, moved, bcnt_q;
  logic [3:0]       s1, d1;

  wire [1:0]    wc       = beat_code(c0[3:2], c0[5:4]);
  wire [DW-1:0] bb       = beat_bytes(wc);
  wire          mem_fire = mem_req && mem_ack;

  // named events for the register block and the assertions
  wire park      = (st == ST_FETCH) && (fidx == IDX_W'(IDX_C0)) && mem_fire && !mem_rdata[0];
  wire desc_ok   = (st == ST_FETCH) && (fidx == IDX_W'(IDX_C0)) && mem_fire &&  mem_rdata[0];
  wire desc_done = (st == ST_WB_CMD) && mem_fire;
  wire last_fet  = (st == ST_FETCH) && (fidx == IDX_W'(IDX_NEXT)) && mem_fire;
  wire beat_done = (st == ST_WR) && mem_fire;

  assign fetch_go = (st == ST_IDLE) && en && dbell_pend;
  assign dptr_wr  = desc_done;
  assign dptr_nxt = nx;
  assign irq_set  = desc_done && c0[1];
  assign cv_set   = desc_ok;
  assign cv_clr   = desc_done;
  assign idle     = (st == ST_IDLE);
  assign bcnt     = bcnt_q;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dptr;
    mem_size  = 2'd2;
    mem_wdata = '0;
    case (st)
      ST_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = dptr + DW'({fidx, 2'b00});
      end
      ST_RD: begin
        mem_req  = 1'b1;
        mem_addr = side_addr(s0, s1, moved, wc);
        mem_size = wc;
      end
      ST_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = side_addr(d0, d1, moved, wc);
        mem_size  = wc;
        mem_wdata = buf_q;
      end
      ST_WB_STAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dptr + DW'(IDX_STAT * 4);
        mem_wdata = c1 | {1'b1, {(DW-1){1'b0}}};
      end
      ST_WB_CMD: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = c0 & ~DW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      fidx   <= '0;
      c0     <= '0;
      c1     <= '0;
      s0     <= '0;
      s1     <= '0;
      d0     <= '0;
      d1     <= '0;
      nx     <= '0;
      buf_q  <= '0;
      moved  <= '0;
      bcnt_q <= '0;
    end else begin
      case (st)
        ST_IDLE: if (fetch_go) begin
          st   <= ST_FETCH;
          fidx <= '0;
        end
        ST_FETCH: if (mem_fire) begin
          case (fidx)
            IDX_W'(IDX_C0): c0 <= mem_rdata;
            IDX_W'(IDX_C1): begin c1 <= mem_rdata; bcnt_q <= mem_rdata; end
            IDX_W'(IDX_S0): s0 <= mem_rdata;
            IDX_W'(IDX_S1): s1 <= mem_rdata[3:0];
            IDX_W'(IDX_D0): d0 <= mem_rdata;
            IDX_W'(IDX_D1): d1 <= mem_rdata[3:0];
            IDX_W'(IDX_NEXT): nx <= mem_rdata;
            default: ;
          endcase
          moved <= '0;
          if (park)          st <= ST_IDLE;
          else if (last_fet) st <= !en ? ST_IDLE : ((c1 == '0) ? ST_WB_STAT : ST_RD);
          else if (!en)      st <= ST_IDLE;
          else fidx <= (fidx == IDX_W'(IDX_D1)) ? IDX_W'(IDX_NEXT) : fidx + IDX_W'(1);
        end
        ST_RD: if (mem_fire) begin
          buf_q <= mem_rdata;
          st    <= ST_WR;
        end
        ST_WR: if (beat_done) begin
          moved  <= moved + bb;
          bcnt_q <= (bcnt_q > bb) ? bcnt_q - bb : '0;
          if (bcnt_q <= bb) st <= ST_WB_STAT;
          else              st <= en ? ST_RD : ST_IDLE;
        end
        ST_WB_STAT: if (mem_fire) st <= ST_WB_CMD;
        ST_WB_CMD: if (desc_done) begin
          st   <= en ? ST_FETCH : ST_IDLE;
          fidx <= '0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R11: an unanswered request holds still
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_size) && $stable(mem_wdata)));
  // R2: parking on an invalid descriptor leaves the bus quiet
  p_park_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> !mem_req);
  // R7: a zero-count descriptor never reaches a data read
  p_no_data_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD) |-> (c1 != '0));
  // R6: a write-back is always followed by the command-word write
  p_wb_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_WB_STAT) && mem_fire) |=> (st == ST_WB_CMD));
endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
  import desc_dma_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [DW-1:0]     mem_addr,
  output logic [1:0]        mem_size,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata
);
  logic          en, dbell_pend, fetch_go, dptr_wr, irq_set, cv_set, cv_clr, idle;
  logic [DW-1:0] dptr, dptr_nxt, bcnt;

  desc_dma_regs #(.REG_AW(REG_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en(en), .dbell_pend(dbell_pend),
    .dptr(dptr), .irq(irq), .fetch_go(fetch_go), .dptr_wr(dptr_wr),
    .dptr_nxt(dptr_nxt), .irq_set(irq_set), .cv_set(cv_set), .cv_clr(cv_clr),
    .idle(idle), .bcnt(bcnt)
  );

  desc_dma_engine u_eng (
    .clk(clk), .rst_n(rst_n), .en(en), .dbell_pend(dbell_pend), .dptr(dptr),
    .fetch_go(fetch_go), .dptr_wr(dptr_wr), .dptr_nxt(dptr_nxt), .irq_set(irq_set),
    .cv_set(cv_set), .cv_clr(cv_clr), .idle(idle), .bcnt(bcnt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/desc_dma_channel_tb_top.sv
module desc_dma_channel_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CFG = 8'h00, A_DPTR = 8'h04, A_DBELL = 8'h08,
                         A_IRQ = 8'h0C, A_BCNT = 8'h10, A_STAT = 8'h14;

  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic irq, mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0] mem_size;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_dma_channel dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_tests = 0, n_fail = 0, dbeats = 0;
  bit done = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] bmem [0:4095];
  int wcnt = 0, lat = 0;

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [31:0] rdn(input logic [31:0] a, input int n);
    logic [31:0] v = 0;
    for (int b = 0; b < n; b++) v[8*b +: 8] = bmem[(a + b) & 32'hFFF];
    return v;
  endfunction
  task automatic wr32(input logic [31:0] a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) bmem[(a + b) & 32'hFFF] = v[8*b +: 8];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
      wcnt <= 0;
    end else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wcnt == 0) begin
        mem_ack <= 1'b1;
        lat = (lat + 1) % 3;
        wcnt <= lat;
        if (mem_we)
          for (int b = 0; b < nbytes(mem_size); b++) bmem[(mem_addr + b) & 32'hFFF] = mem_wdata[8*b +: 8];
        else mem_rdata <= rdn(mem_addr, nbytes(mem_size));
      end else wcnt <= wcnt - 1;
    end
  end

  // ---------------- reference model: expected bus transactions ----------------
  typedef struct { bit we; logic [31:0] addr; logic [1:0] size; logic [31:0] data; bit cd; bit dbeat; string tag; } txn_t;
  txn_t expq[$];

  task automatic push(input bit we, input logic [31:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input bit cd, input bit db, input string tag);
    txn_t t;
    t.we = we; t.addr = a; t.size = sz; t.data = d; t.cd = cd; t.dbeat = db; t.tag = tag;
    expq.push_back(t);
  endtask

  function automatic int wbytes(input logic [1:0] code);
    return (code == 2'd0) ? 1 : (code == 2'd1) ? 2 : 4;
  endfunction
  function automatic logic [31:0] m_addr(input logic [31:0] base, input logic [31:0] attr, input int off, input int w);
    int units = 1 << attr[3:2];
    case (attr[1:0])
      2'd0: return base + off;
      2'd1: return base;
      default: return base + (off % (units * w));
    endcase
  endfunction

  // R2/R4/R5/R6/R7: expand one descriptor into its transactions
  task automatic model_desc(input logic [31:0] p);
    logic [31:0] c0, c1, s0, s1, d0, d1, sa, da;
    int w, n;
    logic [1:0] code;
    c0 = rdn(p, 4);
    push(0, p, 2'd2, 0, 0, 0, "R2 cmd0 fetch");
    if (!c0[0]) return;
    c1 = rdn(p + 4, 4); s0 = rdn(p + 8, 4); s1 = rdn(p + 12, 4);
    d0 = rdn(p + 16, 4); d1 = rdn(p + 20, 4);
    for (int i = 1; i < 6; i++) push(0, p + 4*i, 2'd2, 0, 0, 0, "R2 fetch order");
    push(0, p + 28, 2'd2, 0, 0, 0, "R2 next fetch");
    w = wbytes(c0[3:2]);
    if (wbytes(c0[5:4]) < w) w = wbytes(c0[5:4]);
    code = (w == 1) ? 2'd0 : (w == 2) ? 2'd1 : 2'd2;
    n = (c1 + w - 1) / w;
    for (int k = 0; k < n; k++) begin
      sa = m_addr(s0, s1, k*w, w);
      da = m_addr(d0, d1, k*w, w);
      push(0, sa, code, 0, 0, 0, "R5 source beat");
      push(1, da, code, rdn(sa, w), 1, 1, "R4 dest beat");
    end
    push(1, p + 24, 2'd2, c1 | 32'h8000_0000, 1, 0, "R6 status word");
    push(1, p, 2'd2, c0 & ~32'h1, 1, 0, "R6 valid clear");
  endtask

  // ---------------- monitor, compared every clock ----------------
  bit prev_wait = 0;
  logic [31:0] prev_addr = 0;
  always @(negedge clk) if (rst_n) begin
    if (prev_wait) begin
      chk("R11 req held", {31'b0, mem_req}, 32'd1);
      chk("R11 addr held", mem_addr, prev_addr);
    end
    prev_wait = mem_req && !mem_ack;
    prev_addr = mem_addr;
    if (mem_req && mem_ack) begin
      if (expq.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R11 unexpected access: got %h expected none", mem_addr);
      end else begin
        txn_t e;
        logic [31:0] m;
        e = expq.pop_front();
        m = (e.size == 2'd0) ? 32'hFF : (e.size == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
        chk({e.tag, " dir"}, {31'b0, mem_we}, {31'b0, e.we});
        chk({e.tag, " addr"}, mem_addr, e.addr);
        chk({e.tag, " size"}, {30'b0, mem_size}, {30'b0, e.size});
        if (e.cd) chk({e.tag, " data"}, mem_wdata & m, e.data);
        if (e.dbeat) dbeats++;
      end
    end
  end

  // ---------------- register access helpers ----------------
  task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask
  task automatic reg_read(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask
  task automatic wait_quiet();
    int still = 0;
    while (still < 8) begin
      @(negedge clk);
      if (expq.size() == 0 && !mem_req) still++;
      else still = 0;
    end
  endtask
  task automatic wdesc(input logic [31:0] p, input logic [31:0] c0, input logic [31:0] c1,
                       input logic [31:0] s0, input logic [31:0] s1, input logic [31:0] d0,
                       input logic [31:0] d1, input logic [31:0] nx);
    wr32(p, c0); wr32(p + 4, c1); wr32(p + 8, s0); wr32(p + 12, s1);
    wr32(p + 16, d0); wr32(p + 20, d1); wr32(p + 24, 0); wr32(p + 28, nx);
  endtask
  task automatic cmp_bytes(input string tag, input logic [31:0] dst, input logic [31:0] src, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++) if (bmem[dst + i] !== bmem[src + i]) bad++;
    chk(tag, bad, 0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] v;
    int b0, nst;
    for (int i = 0; i < 4096; i++) bmem[i] = 8'h00;
    for (int i = 0; i < 256; i++) bmem[12'h400 + i] = 8'(i * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    reg_read(A_CFG, v);  chk("R1 enable after reset", v, 0);
    reg_read(A_STAT, v); chk("R1 halt after reset", v, 32'h1);
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 no request after reset", {31'b0, mem_req}, 0);

    // R2 park on invalid descriptor
    wdesc(32'h000, 32'h0, 8, 32'h400, 0, 32'h800, 0, 32'h020);
    model_desc(32'h000);
    reg_write(A_DPTR, 32'h000);
    reg_write(A_CFG, 1);
    reg_write(A_DBELL, 0);
    wait_quiet();
    chk("R2 parked, single cmd0 read", expq.size(), 0);
    reg_read(A_STAT, v); chk("R2 parked and enabled, no halt", v, 0);

    // R3/R6/R7/R8 chain: word copy -> zero count -> invalid
    wdesc(32'h000, 32'h2B, 8, 32'h400, 0, 32'h800, 0, 32'h020);
    wdesc(32'h020, 32'h2B, 0, 32'h400, 0, 32'h810, 0, 32'h040);
    wdesc(32'h040, 32'h0, 4, 32'h400, 0, 32'h820, 0, 32'h060);
    model_desc(32'h000); model_desc(32'h020); model_desc(32'h040);
    reg_write(A_DBELL, 0);
    wait_quiet();
    cmp_bytes("R4 word copy data", 32'h800, 32'h400, 8);
    chk("R6 status word A", rdn(32'h018, 4), 32'h8000_0008);
    chk("R6 cmd0 valid cleared A", rdn(32'h000, 4), 32'h2A);
    chk("R7 zero count status", rdn(32'h038, 4), 32'h8000_0000);
    chk("R7 zero count no dest write", rdn(32'h810, 4), 0);
    reg_read(A_DPTR, v); chk("R6 pointer follows chain", v, 32'h040);
    chk("R8 irq raised", {31'b0, irq}, 1);
    reg_read(A_IRQ, v); chk("R8 irq register", v, 1);
    reg_write(A_IRQ, 0);
    chk("R8 irq cleared by write", {31'b0, irq}, 0);

    // R4/R5 byte static source into word incrementing destination
    wdesc(32'h060, 32'h21, 3, 32'h410, 32'h1, 32'h840, 0, 32'h080);
    wdesc(32'h080, 32'h0, 0, 0, 0, 0, 0, 0);
    model_desc(32'h060); model_desc(32'h080);
    reg_write(A_DPTR, 32'h060);
    reg_write(A_DBELL, 0);
    wait_quiet();
    chk("R5 static source", {8'h0, bmem[12'h840], bmem[12'h841], bmem[12'h842]},
        {8'h0, bmem[12'h410], bmem[12'h410], bmem[12'h410]});
    chk("R8 no irq without enable bit", {31'b0, irq}, 0);

    // R4/R5 word source into halfword burst-window destination (2 units)
    wdesc(32'h0A0, 32'h19, 8, 32'h420, 0, 32'h880, 32'h6, 32'h0C0);
    wdesc(32'h0C0, 32'h0, 0, 0, 0, 0, 0, 0);
    model_desc(32'h0A0); model_desc(32'h0C0);
    reg_write(A_DPTR, 32'h0A0);
    reg_write(A_DBELL, 0);
    wait_quiet();
    cmp_bytes("R5 burst window wrap", 32'h880, 32'h424, 4);
    chk("R5 burst stays in window", rdn(32'h884, 4), 0);

    // R9/R10 disable in mid transfer
    wdesc(32'h0E0, 32'h29, 64, 32'h440, 0, 32'h900, 0, 32'h100);
    wdesc(32'h100, 32'h0, 0, 0, 0, 0, 0, 0);
    model_desc(32'h0E0);
    b0 = dbeats;
    reg_write(A_DPTR, 32'h0E0);
    reg_write(A_DBELL, 0);
    while (dbeats < b0 + 3) @(negedge clk);
    reg_write(A_CFG, 0);
    do reg_read(A_STAT, v); while (!v[0]);
    nst = dbeats - b0;
    repeat (6) @(negedge clk);
    chk("R9 no request after halt", {31'b0, mem_req}, 0);
    chk("R9 stopped before end", {31'b0, nst < 16}, 1);
    reg_read(A_BCNT, v); chk("R9 remaining bytes", v, 32'(64 - 4*nst));
    expq.delete();
    reg_read(A_STAT, v); chk("R10 current valid while stopped", v, 32'h5);
    reg_write(A_STAT, 32'h4);
    reg_read(A_STAT, v); chk("R10 current valid cleared", v, 32'h1);
    reg_write(A_DBELL, 0);
    repeat (4) @(negedge clk);
    chk("R3 doorbell while disabled", {31'b0, mem_req}, 0);
    reg_read(A_STAT, v); chk("R3 pending bit set", v, 32'h3);
    reg_write(A_STAT, 32'h2);
    reg_read(A_STAT, v); chk("R10 pending cleared", v, 32'h1);

    // R3 resume restarts the descriptor in full
    reg_write(A_CFG, 1);
    repeat (4) @(negedge clk);
    chk("R3 enable alone does not fetch", {31'b0, mem_req}, 0);
    model_desc(32'h0E0); model_desc(32'h100);
    reg_write(A_DBELL, 0);
    wait_quiet();
    cmp_bytes("R3 resumed transfer complete", 32'h900, 32'h440, 64);
    chk("R6 status after resume", rdn(32'h0F8, 4), 32'h8000_0040);
    reg_read(A_STAT, v); chk("R3 enabled park not halted", v, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule